// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers a parameterized set of interrupt request lines, each tagged with a three-bit priority, and reduces them to a single pending priority for the processor. Among the active requests it takes the largest priority. It presents that priority only when it is above the processor's current interrupt mask. Priority 7 is non-maskable and is always presented. Priority 0 means that nothing is pending, so a request tagged 0 can never interrupt.

When the processor acknowledges, the block captures the presented priority and then samples an active-low strap. If the strap is low, the block produces the fixed autovector for that priority: vector 24 plus the priority, giving vectors 25 to 31. If the strap is high, the block raises an acknowledge line toward the device for one cycle and takes the device's vector number. In both cases the result is a byte offset into the vector table, equal to the vector number times four. A one-cycle done pulse marks the offset as valid. Fetching the table entry and running the handler are outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `ipl_o`, `irq_o`, `dev_ack_o`, `done_o` and `vec_off_o` are all zero.
- R2: One clock after the inputs are applied, `ipl_o` equals the largest priority among the requests whose `req_i` bit is 1. Request i's priority is `req_lvl_i[3*i+2:3*i]`.
- R3: `ipl_o` is nonzero only if that largest priority is greater than `mask_i`, or is 7. Otherwise `ipl_o` is 0.
- R4: `irq_o` is 1 exactly when `ipl_o` is nonzero.
- R5: An `iack_i` pulse is accepted only while the controller is idle and `irq_o` is 1. Accepting it latches the current `ipl_o`. A pulse with `irq_o` low, or one that arrives during an acknowledge, has no effect on `done_o`, `dev_ack_o` or `vec_off_o`.
- R6: If `avec_ni` is 0 in the cycle after acceptance, the offset is (24 + latched priority) * 4.
- R7: If `avec_ni` is 1 in that cycle, `dev_ack_o` is 1 for exactly that cycle, and the offset is `dev_vec_i` * 4, sampled in the same cycle. `dev_ack_o` is never 1 in any other cycle.
- R8: `done_o` is high for exactly one cycle, two clocks after the accepting edge. `vec_off_o` shows the new offset from that cycle onward and holds it until the next acknowledge completes.
- R9: A request whose priority is 0 never makes `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Interrupt request lines, active high |
| req_lvl_i | input | 3*N_REQ | Priority of each request line, three bits per line |
| mask_i | input | 3 | Current processor interrupt mask |
| iack_i | input | 1 | Acknowledge strobe from the processor |
| avec_ni | input | 1 | Autovector strap, active low |
| dev_vec_i | input | VEC_W | Vector number supplied by the device |
| ipl_o | output | 3 | Presented interrupt priority |
| irq_o | output | 1 | Interrupt pending |
| dev_ack_o | output | 1 | Acknowledge to the device, user-vector mode only |
| done_o | output | 1 | Vector offset valid pulse |
| vec_off_o | output | VEC_W+2 | Byte offset into the vector table |

## Verification
The priority reduction is driven in four ways:
- Sparse single requests show which line wins.
- Dense random request sets with random priority tags show the maximum search over many contenders.
- Requests tagged 0 show that they are never counted.
- Sweeps of the mask, which cross priority 6 and priority 7, show the mask comparison and the non-maskable case.

Acknowledges are issued with the strap held low at every priority, which tells apart the seven autovector offsets. They are also issued with the strap high and device vectors of 0, 255 and random values, which checks the shift and the device acknowledge. Some acknowledges arrive with nothing pending and some arrive during a busy sequence; these show that a pulse is accepted only when it is valid.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned AUTO_BASE = 24;
  localparam int unsigned NMI_LVL   = 7;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_SAMPLE = 2'd1,
    ACK_DONE   = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_lvl_reduce.sv
module irq_lvl_reduce
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_REQ = 16
) (
  input  logic [N_REQ-1:0]       req_i,
  input  logic [N_REQ*LVL_W-1:0] req_lvl_i,
  output lvl_t                   best_o
);
  lvl_t act_lvl [N_REQ];

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    assign act_lvl[g] = req_i[g] ? req_lvl_i[g*LVL_W +: LVL_W] : '0;
  end

  always_comb begin
    best_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (act_lvl[i] > best_o) best_o = act_lvl[i];
    end
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_vec_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned OFF_W = VEC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iack_i,
  input  logic             irq_i,
  input  lvl_t             ipl_i,
  input  logic             avec_ni,
  input  logic [VEC_W-1:0] dev_vec_i,
  output logic             dev_ack_o,
  output logic             done_o,
  output logic [OFF_W-1:0] vec_off_o
);
  ack_state_e state_q;
  lvl_t       lvl_q;
  logic [VEC_W-1:0] auto_vec;

  assign auto_vec  = VEC_W'(AUTO_BASE) + VEC_W'(lvl_q);
  assign dev_ack_o = (state_q == ACK_SAMPLE) && avec_ni;
  assign done_o    = (state_q == ACK_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ACK_IDLE;
      lvl_q     <= '0;
      vec_off_o <= '0;
    end else begin
      unique case (state_q)
        ACK_IDLE: if (iack_i && irq_i) begin
          lvl_q   <= ipl_i;
          state_q <= ACK_SAMPLE;
        end
        ACK_SAMPLE: begin
          // strap low forces the fixed per-level vector
          vec_off_o <= avec_ni ? {dev_vec_i, 2'b00} : {auto_vec, 2'b00};
          state_q   <= ACK_DONE;
        end
        ACK_DONE: state_q <= ACK_IDLE;
        default:  state_q <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_REQ = 16,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned OFF_W = VEC_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       req_i,
  input  logic [N_REQ*LVL_W-1:0] req_lvl_i,
  input  logic [LVL_W-1:0]       mask_i,
  input  logic                   iack_i,
  input  logic                   avec_ni,
  input  logic [VEC_W-1:0]       dev_vec_i,
  output logic [LVL_W-1:0]       ipl_o,
  output logic                   irq_o,
  output logic                   dev_ack_o,
  output logic                   done_o,
  output logic [OFF_W-1:0]       vec_off_o
);
  lvl_t best;
  logic pass;

  irq_lvl_reduce #(.N_REQ(N_REQ)) u_reduce (
    .req_i    (req_i),
    .req_lvl_i(req_lvl_i),
    .best_o   (best)
  );

  // level 7 bypasses the mask
  assign pass = (best > mask_i) || (best == lvl_t'(NMI_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_o <= '0;
      irq_o <= 1'b0;
    end else begin
      ipl_o <= pass ? best : '0;
      irq_o <= pass && (best != '0);
    end
  end

  irq_ack_fsm #(.VEC_W(VEC_W)) u_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .iack_i   (iack_i),
    .irq_i    (irq_o),
    .ipl_i    (ipl_o),
    .avec_ni  (avec_ni),
    .dev_vec_i(dev_vec_i),
    .dev_ack_o(dev_ack_o),
    .done_o   (done_o),
    .vec_off_o(vec_off_o)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int unsigned OFF_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mask_i,
  input logic             avec_ni,
  input logic [2:0]       ipl_o,
  input logic             irq_o,
  input logic             dev_ack_o,
  input logic             done_o,
  input logic [OFF_W-1:0] vec_off_o
);
  assert_irq_matches_ipl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ipl_o != 3'd0));

  assert_mask_respected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_o != 3'd0 && ipl_o != 3'd7) |-> (ipl_o > $past(mask_i)));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_dev_ack_user_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |-> (avec_ni && !done_o));

  assert_dev_ack_then_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |=> done_o);

  assert_auto_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(avec_ni)) |->
      (vec_off_o[OFF_W-1:2] >= (OFF_W-2)'(25) && vec_off_o[OFF_W-1:2] <= (OFF_W-2)'(31)));

  assert_offset_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_off_o[1:0] == 2'b00);
endmodule

bind irq_vec_ctrl irq_vec_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mask_i   (mask_i),
  .avec_ni  (avec_ni),
  .ipl_o    (ipl_o),
  .irq_o    (irq_o),
  .dev_ack_o(dev_ack_o),
  .done_o   (done_o),
  .vec_off_o(vec_off_o)
);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/100ps
module irq_vec_ctrl_test;
  localparam int N_REQ = 16;
  localparam int VEC_W = 8;
  localparam int OFF_W = VEC_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_REQ-1:0]   req = '0;
  logic [N_REQ*3-1:0] lvl = '0;
  logic [2:0]         mask = '0;
  logic               iack = 1'b0;
  logic               avec_n = 1'b0;
  logic [VEC_W-1:0]   dvec = '0;
  logic [2:0]         ipl;
  logic               irq, dack, done;
  logic [OFF_W-1:0]   voff;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl #(.N_REQ(N_REQ), .VEC_W(VEC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_lvl_i(lvl), .mask_i(mask),
    .iack_i(iack), .avec_ni(avec_n), .dev_vec_i(dvec),
    .ipl_o(ipl), .irq_o(irq), .dev_ack_o(dack), .done_o(done), .vec_off_o(voff)
  );

  // behavioural reference
  int m_ipl, m_state, m_lvl, m_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ipl = 0; m_state = 0; m_lvl = 0; m_off = 0;
    end else begin
      int best, nxt;
      best = 0;
      for (int i = 0; i < N_REQ; i++)
        if (req[i] && int'(lvl[3*i +: 3]) > best) best = int'(lvl[3*i +: 3]);
      nxt = (best > int'(mask) || best == 7) ? best : 0;
      case (m_state)
        0: if (iack && m_ipl != 0) begin m_lvl = m_ipl; m_state = 1; end
        1: begin
          m_off = avec_n ? int'(dvec) * 4 : (24 + m_lvl) * 4;
          m_state = 2;
        end
        default: m_state = 0;
      endcase
      m_ipl = nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 R3 R9 ipl", int'(ipl), m_ipl);
    chk("R4 irq", int'(irq), int'(m_ipl != 0));
    chk("R5 R8 done", int'(done), int'(m_state == 2));
    chk("R5 R7 dev_ack", int'(dack), int'(m_state == 1 && avec_n));
    chk("R6 R7 R8 vec_off", int'(voff), m_off);
  end

  task automatic step(); @(negedge clk); #0.5; endtask

  task automatic set_one(input int idx, input int l);
    req = '0; req[idx] = 1'b1; lvl[3*idx +: 3] = 3'(l);
  endtask

  task automatic do_ack(input bit auto_mode, input logic [VEC_W-1:0] v);
    iack = 1'b1; step(); iack = 1'b0;
    avec_n = ~auto_mode; dvec = v; step(); step(); step();
  endtask

  initial begin
    #1;
    chk("R1 ipl", int'(ipl), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dev_ack", int'(dack), 0);
    chk("R1 vec_off", int'(voff), 0);
    step(); rst_n = 1'b1; step();

    // R5: ack with nothing pending
    iack = 1'b1; step(); step(); iack = 1'b0; step(); step();

    // R6: autovector at every level
    for (int l = 1; l < 8; l++) begin
      mask = 3'd0; set_one(l, l); step(); do_ack(1'b1, 8'hAA);
    end
    // R7: user vectors at edges
    set_one(3, 5); step(); do_ack(1'b0, 8'h00);
    do_ack(1'b0, 8'hFF);
    do_ack(1'b0, 8'h40);
    // R5: iack held through a busy sequence
    iack = 1'b1; step(); avec_n = 1'b1; dvec = 8'h12; step(); step(); step(); iack = 1'b0; step();

    // R3: mask sweep around 6 and 7
    req = '0; lvl = '0; req[0] = 1'b1; lvl[2:0] = 3'd6; req[1] = 1'b1; lvl[5:3] = 3'd0;
    for (int m = 0; m < 8; m++) begin mask = 3'(m); step(); step(); end
    lvl[2:0] = 3'd7;
    for (int m = 0; m < 8; m++) begin mask = 3'(m); step(); step(); end

    // R9: only level-0 tagged requests active
    mask = 3'd0; lvl = '0; req = '1; step(); step();

    // R2: random request sets
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0)
        for (int i = 0; i < N_REQ; i++) lvl[3*i +: 3] = 3'($urandom_range(0, 7));
      req    = N_REQ'($urandom);
      if (n % 3 == 0) req = req & N_REQ'($urandom);
      mask   = 3'($urandom_range(0, 7));
      iack   = ($urandom_range(0, 3) == 0);
      avec_n = 1'($urandom);
      dvec   = VEC_W'($urandom);
      step();
    end
    iack = 1'b0; step(); step(); step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule